// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through cache and a slower memory. Every store the processor sends is queued here, and a drain path copies the queued stores to memory one at a time, oldest first. The processor continues as soon as a store is queued. It only stalls when all slots are occupied.

Read misses share the single memory port with the drain path and are given precedence. When the port is free and a read is waiting, the read is chosen over the oldest queued store. Before a read is sent to memory, its address is compared with every occupied slot at once. If a slot holds that address, the read is answered from the queue and memory is not accessed. When more than one slot holds the address, the most recently queued one supplies the data. This prevents a read from returning a value that memory has not yet received.

The memory port carries one transaction at a time. The block holds the transaction until memory acknowledges it. A queued store leaves the queue in the cycle its acknowledge arrives.

Top module: `write_drain_buffer`

## Requirements
- R1: After reset, `wr_full_o`, `mem_req_o` and `rd_valid_o` are low and the queue is empty.
- R2: Stores reach memory in the order they were accepted, one memory write per acknowledge. A slot is freed in the cycle its acknowledge is seen.
- R3: `wr_full_o` is high when every slot is occupied (DEPTH slots, 4 by default). A store offered while `wr_full_o` is high is dropped and never reaches memory.
- R4: A store accepted in the same cycle as a drain acknowledge leaves the occupancy unchanged.
- R5: When the port is idle and a read is waiting, the read is issued before any queued store. A read that arrives while a store is in flight waits for that store's acknowledge.
- R6: A read that matches no slot issues one memory read (`mem_we_o` low). `rd_valid_o` pulses for one cycle, in the cycle after `mem_ack_i`, with `rd_data_o` equal to `mem_rdata_i`.
- R7: A read whose address matches an occupied slot issues no memory transaction. It is answered with the queued data one cycle after it is arbitrated.
- R8: When several occupied slots hold the read address, the data comes from the most recently accepted one.
- R9: Once `mem_req_o` rises, it stays high with `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stable until the cycle `mem_ack_i` is high.
- R10: `rd_req_i` is held until `rd_valid_o` is seen. A request still high in the `rd_valid_o` cycle is ignored, so each read produces exactly one single-cycle `rd_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Store offered this cycle |
| wr_addr_i | input | AW | Store word address |
| wr_data_i | input | DW | Store data |
| wr_full_o | output | 1 | All slots occupied; stores are dropped |
| rd_req_i | input | 1 | Read miss request, held until answered |
| rd_addr_i | input | AW | Read word address |
| rd_valid_o | output | 1 | Read data valid, one-cycle pulse |
| rd_data_o | output | DW | Read data |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | DW | Memory read data, valid with the acknowledge |

## Verification
The assertions check these properties on every cycle:
- the memory request stays stable until acknowledged;
- the occupancy changes correctly on a drain acknowledge, on a store accepted during a drain acknowledge, and at full;
- a store is never started while a read is waiting;
- `rd_valid_o` never lasts more than one cycle.

Some behaviours need whole sequences and only the directed scenarios can show them:
- that stores reach memory in order;
- that a dropped store never appears at memory;
- that a read is answered from the queue while memory still holds an older value;
- that the youngest of several matching slots wins.

// File: rtl/wdb_pkg.sv
`timescale 1ns/1ps
package wdb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } port_state_e;
endpackage

// File: rtl/wdb_queue.sv
`timescale 1ns/1ps
module wdb_queue #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [AW-1:0]       push_addr_i,
  input  logic [DW-1:0]       push_data_i,
  input  logic                pop_i,
  output logic [AW-1:0]       head_addr_o,
  output logic [DW-1:0]       head_data_o,
  output logic [PW-1:0]       head_ptr_o,
  output logic [PW:0]         occ_o,
  output logic                full_o,
  output logic                empty_o,
  output logic [DEPTH*AW-1:0] addr_flat_o,
  output logic [DEPTH*DW-1:0] data_flat_o
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [PW:0]   occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      if (push_i && !pop_i)      occ_q <= occ_q + 1'b1;
      else if (pop_i && !push_i) occ_q <= occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign addr_flat_o[g*AW +: AW] = addr_q[g];
    assign data_flat_o[g*DW +: DW] = data_q[g];
  end

  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];
  assign head_ptr_o  = rd_ptr_q;
  assign occ_o       = occ_q;
  assign full_o      = (occ_q == (PW+1)'(DEPTH));
  assign empty_o     = (occ_q == '0);
endmodule

// File: rtl/wdb_lookup.sv
`timescale 1ns/1ps
module wdb_lookup #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [DEPTH*AW-1:0] addr_flat_i,
  input  logic [DEPTH*DW-1:0] data_flat_i,
  input  logic [PW-1:0]       head_ptr_i,
  input  logic [PW:0]         occ_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic                hit_o,
  output logic [DW-1:0]       hit_data_o
);
  logic [PW-1:0] slot;

  // walk oldest to youngest; a later match overrides, so the youngest wins
  always_comb begin
    hit_o      = 1'b0;
    hit_data_o = '0;
    slot       = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_ptr_i + PW'(k);
      if (((PW+1)'(k) < occ_i) && (addr_flat_i[slot*AW +: AW] == rd_addr_i)) begin
        hit_o      = 1'b1;
        hit_data_o = data_flat_i[slot*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/wdb_port_arb.sv
`timescale 1ns/1ps
module wdb_port_arb
  import wdb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          hit_i,
  input  logic [DW-1:0] hit_data_i,
  input  logic          empty_i,
  input  logic [AW-1:0] head_addr_i,
  input  logic [DW-1:0] head_data_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          pop_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  port_state_e   state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q;
  logic          rd_take;

  // a request seen while the previous answer is on the port is the same read
  assign rd_take = rd_req_i && !rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rd_take) begin
            if (hit_i) begin
              rvalid_q <= 1'b1;
              rdata_q  <= hit_data_i;
            end else begin
              state_q <= ST_RD;
              addr_q  <= rd_addr_i;
            end
          end else if (!empty_i) begin
            state_q <= ST_WR;
            addr_q  <= head_addr_i;
            wdata_q <= head_data_i;
          end
        end
        ST_RD: begin
          if (mem_ack_i) begin
            state_q  <= ST_IDLE;
            rvalid_q <= 1'b1;
            rdata_q  <= mem_rdata_i;
          end
        end
        ST_WR: begin
          if (mem_ack_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pop_o       = (state_q == ST_WR) && mem_ack_i;
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign rd_valid_o  = rvalid_q;
  assign rd_data_o   = rdata_q;
endmodule

// File: rtl/write_drain_buffer.sv
`timescale 1ns/1ps
module write_drain_buffer #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_full_o,
  input  logic          rd_req_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic                push, pop, full, empty, hit;
  logic [AW-1:0]       head_addr;
  logic [DW-1:0]       head_data, hit_data;
  logic [PW-1:0]       head_ptr;
  logic [PW:0]         occ;
  logic [DEPTH*AW-1:0] addr_flat;
  logic [DEPTH*DW-1:0] data_flat;

  assign push      = wr_valid_i && !full;
  assign wr_full_o = full;

  wdb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (wr_addr_i),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .head_addr_o (head_addr),
    .head_data_o (head_data),
    .head_ptr_o  (head_ptr),
    .occ_o       (occ),
    .full_o      (full),
    .empty_o     (empty),
    .addr_flat_o (addr_flat),
    .data_flat_o (data_flat)
  );

  wdb_lookup #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_lookup (
    .addr_flat_i (addr_flat),
    .data_flat_i (data_flat),
    .head_ptr_i  (head_ptr),
    .occ_i       (occ),
    .rd_addr_i   (rd_addr_i),
    .hit_o       (hit),
    .hit_data_o  (hit_data)
  );

  wdb_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_req_i),
    .rd_addr_i   (rd_addr_i),
    .hit_i       (hit),
    .hit_data_i  (hit_data),
    .empty_i     (empty),
    .head_addr_i (head_addr),
    .head_data_i (head_data),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .pop_o       (pop),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/wdb_checker.sv
`timescale 1ns/1ps
module wdb_checker #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          wr_full_o,
  input logic          rd_req_i,
  input logic          rd_valid_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic [PW:0]   occ
);
  logic drain_ack;
  assign drain_ack = mem_req_o && mem_we_o && mem_ack_i;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_full_o && !drain_ack |=> wr_full_o); // R3

  AST_PUSH_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && !wr_full_o && drain_ack |=> occ == $past(occ)); // R4

  AST_POP_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_ack && !wr_valid_i |=> (32'(occ) + 1) == 32'($past(occ))); // R2

  AST_DRAIN_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> occ != '0); // R2

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)); // R9

  AST_READ_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && mem_we_o |-> $past(!rd_req_i || rd_valid_o)); // R5

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R10
endmodule

bind write_drain_buffer wdb_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .wr_full_o   (wr_full_o),
  .rd_req_i    (rd_req_i),
  .rd_valid_o  (rd_valid_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .occ         (occ)
);

// File: tb/tb_write_drain_buffer.sv
`timescale 1ns/1ps
module tb_write_drain_buffer;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic wr_full_o;
  logic rd_req_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic rd_valid_o;
  logic [DW-1:0] rd_data_o;
  logic mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic mem_ack_i;
  logic [DW-1:0] mem_rdata_i;

  always #10 clk_i = ~clk_i;

  write_drain_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

  // memory responder
  logic [DW-1:0] mem_model [256];
  logic [AW-1:0] wlog_a [256];
  logic [DW-1:0] wlog_d [256];
  logic          oplog_we [256];
  int wn, opn, rdcnt, cnt, lat;
  int stab_err;
  logic prev_hold, prev_we;
  logic [AW-1:0] prev_addr;

  function automatic logic [DW-1:0] base_val(input int a);
    return 16'hA000 ^ 16'(a);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ack_i   <= 1'b0;
      mem_rdata_i <= '0;
      cnt <= 0; wn <= 0; opn <= 0; rdcnt <= 0;
      for (int i = 0; i < 256; i++) mem_model[i] <= base_val(i);
    end else begin
      mem_ack_i <= 1'b0;
      if (mem_req_o && !mem_ack_i) begin
        if (cnt >= lat) begin
          mem_ack_i <= 1'b1;
          cnt <= 0;
          oplog_we[opn[7:0]] <= mem_we_o;
          opn <= opn + 1;
          if (mem_we_o) begin
            mem_model[mem_addr_o] <= mem_wdata_o;
            wlog_a[wn[7:0]] <= mem_addr_o;
            wlog_d[wn[7:0]] <= mem_wdata_o;
            wn <= wn + 1;
          end else begin
            mem_rdata_i <= mem_model[mem_addr_o];
            rdcnt <= rdcnt + 1;
          end
        end else cnt <= cnt + 1;
      end
    end
  end

  // request stability monitor (R9)
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      prev_hold <= 1'b0; prev_we <= 1'b0; prev_addr <= '0; stab_err <= 0;
    end else begin
      if (prev_hold && (!mem_req_o || mem_addr_o != prev_addr || mem_we_o != prev_we))
        stab_err <= stab_err + 1;
      prev_hold <= mem_req_o && !mem_ack_i;
      prev_addr <= mem_addr_o;
      prev_we   <= mem_we_o;
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                         input bit hold_extra, input string req, output logic [DW-1:0] got);
    int n = 0;
    rd_req_i = 1'b1; rd_addr_i = a;
    @(negedge clk_i);
    while (!rd_valid_o && n < 1000) begin @(negedge clk_i); n++; end
    got = rd_data_o;
    check(rd_valid_o && got == exp, req, int'(got), int'(exp));
    if (hold_extra) @(negedge clk_i);
    rd_req_i = 1'b0;
    @(negedge clk_i);
    check(!rd_valid_o, "R10 pulse", int'(rd_valid_o), 0);
  endtask

  task automatic wait_writes(input int target);
    int n = 0;
    while (wn < target && n < 2000) begin @(negedge clk_i); n++; end
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    check(!wr_full_o, "R1 full", int'(wr_full_o), 0);
    check(!mem_req_o, "R1 req", int'(mem_req_o), 0);
    check(!rd_valid_o, "R1 valid", int'(rd_valid_o), 0);
  endtask

  task automatic t_miss;  // R6, R10
    logic [DW-1:0] got;
    int r0 = rdcnt;
    lat = 2;
    do_read(8'h10, base_val(8'h10), 1'b1, "R6 miss data", got);
    repeat (4) @(negedge clk_i);
    check(rdcnt == r0 + 1, "R10 single memory read", rdcnt - r0, 1);
  endtask

  task automatic t_order;  // R2
    int w0 = wn;
    lat = 1;
    for (int i = 0; i < 4; i++) do_write(AW'(8'h20 + i), DW'(16'h1200 + i));
    wait_writes(w0 + 4);
    for (int i = 0; i < 4; i++) begin
      check(wlog_a[8'(w0 + i)] == AW'(8'h20 + i), "R2 order addr",
            int'(wlog_a[8'(w0 + i)]), 8'h20 + i);
      check(wlog_d[8'(w0 + i)] == DW'(16'h1200 + i), "R2 order data",
            int'(wlog_d[8'(w0 + i)]), 16'h1200 + i);
    end
  endtask

  task automatic t_full;  // R3
    int w0 = wn;
    lat = 30;
    for (int i = 0; i < 4; i++) do_write(AW'(8'h30 + i), DW'(16'h3300 + i));
    check(wr_full_o, "R3 full at depth", int'(wr_full_o), 1);
    do_write(8'h34, 16'h3344);
    wait_writes(w0 + 4);
    repeat (80) @(negedge clk_i);
    check(wn == w0 + 4, "R3 dropped store not written", wn - w0, 4);
    check(mem_model[8'h34] == base_val(8'h34), "R3 memory untouched",
          int'(mem_model[8'h34]), int'(base_val(8'h34)));
  endtask

  task automatic t_same_cycle;  // R4
    int w0 = wn;
    int n = 0;
    lat = 8;
    for (int i = 0; i < 3; i++) do_write(AW'(8'h40 + i), DW'(16'h4400 + i));
    while (!(mem_ack_i && mem_we_o) && n < 100) begin @(negedge clk_i); n++; end
    do_write(8'h43, 16'h4403);
    check(!wr_full_o, "R4 occupancy kept at 3", int'(wr_full_o), 0);
    do_write(8'h44, 16'h4404);
    check(wr_full_o, "R4 fourth slot fills", int'(wr_full_o), 1);
    wait_writes(w0 + 5);
    for (int i = 0; i < 5; i++)
      check(wlog_a[8'(w0 + i)] == AW'(8'h40 + i), "R4 order",
            int'(wlog_a[8'(w0 + i)]), 8'h40 + i);
  endtask

  task automatic t_priority;  // R5
    logic [DW-1:0] got;
    int o0 = opn;
    int w0 = wn;
    lat = 6;
    for (int i = 0; i < 3; i++) do_write(AW'(8'h50 + i), DW'(16'h5500 + i));
    do_read(8'h60, base_val(8'h60), 1'b0, "R5 read data", got);
    wait_writes(w0 + 3);
    check(oplog_we[8'(o0)] == 1'b1, "R5 store in flight first", int'(oplog_we[8'(o0)]), 1);
    check(oplog_we[8'(o0 + 1)] == 1'b0, "R5 read beats queued stores",
          int'(oplog_we[8'(o0 + 1)]), 0);
  endtask

  task automatic t_hit;  // R7
    logic [DW-1:0] got;
    int r0 = rdcnt;
    int w0 = wn;
    lat = 6;
    do_write(8'h70, 16'h1111);
    do_write(8'h71, 16'h2222);
    do_read(8'h71, 16'h2222, 1'b0, "R7 bypass data", got);
    check(rdcnt == r0, "R7 no memory read", rdcnt - r0, 0);
    wait_writes(w0 + 2);
  endtask

  task automatic t_youngest;  // R8
    logic [DW-1:0] got;
    int r0 = rdcnt;
    int w0 = wn;
    lat = 6;
    do_write(8'h90, 16'h0009);
    do_write(8'h80, 16'h0001);
    do_write(8'h81, 16'h0002);
    do_write(8'h80, 16'h0003);
    do_read(8'h80, 16'h0003, 1'b0, "R8 youngest match", got);
    check(rdcnt == r0, "R8 no memory read", rdcnt - r0, 0);
    wait_writes(w0 + 4);
    check(mem_model[8'h80] == 16'h0003, "R8 final memory value",
          int'(mem_model[8'h80]), 3);
  endtask

  initial begin
    lat = 1;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_miss();
    t_order();
    t_full();
    t_same_cycle();
    t_priority();
    t_hit();
    t_youngest();
    check(stab_err == 0, "R9 request stable until ack", stab_err, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 act=timeout exp=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule